// File: doc/BRIEF.md
# Cascadable Row Data Capture with Reversible Fill Order

This block collects one display row of pixel codes for a column driver. On every clock it takes six 6-bit values (two RGB pixels) and stores them as one group of six channels in a first-stage row buffer. A capture run starts when a start pulse rises on whichever of the two start/cascade pins currently acts as the input. From then on, one group is written per clock. The groups run upward from the lowest channels or downward from the highest channels, depending on a direction input. Either half of each incoming group can be bit-complemented on its way in. This lets the source send inverted data to cut line switching.

After the last group of the row is written, the block drives a single-clock pulse on the other start/cascade pin. That pin feeds the start input of the next driver in a daisy chain. The row buffer contents are presented flat to the following stage, which holds and converts them. Each bidirectional pin is modelled as a separate input, output and output enable.

Top module: `rowcap_top`

## Requirements
- R1: While reset is asserted, and right after it is released, every bit of `rowBuf` is 0 and both `startA_out` and `startB_out` are 0.
- R2: Input value k (k = 0..5) is `pixIn[6k+5:6k]`, with bit 5 as the MSB. Channel c (c = 1..CHANNELS) sits in `rowBuf[6(c-1)+5:6(c-1)]`. The six values of one clock land in six adjacent channels in ascending order of k.
- R3: When `invLo` is 1 at a capturing edge, values 0, 1 and 2 are stored bitwise complemented (for example 00h becomes 3Fh and 07h becomes 38h). When it is 0 they are stored unchanged.
- R4: `invHi` complements values 3, 4 and 5 in the same way. It acts independently of `invLo`.
- R5: With `dirRight` = 1, pin A is the start input and pin B carries the cascade pulse, so `startA_oe` = 0 and `startB_oe` = 1. With `dirRight` = 0 the roles and enables swap. The pin in the output role never starts a capture.
- R6: Capture begins at the rising edge that first samples the start input high after it was sampled low, and the data on that same edge is written. With `dirRight` = 1, edge n of the run (n = 0..CHANNELS/6-1) writes channels 6n+1..6n+6.
- R7: With `dirRight` = 0, edge n of the run writes channels CHANNELS-6n-5..CHANNELS-6n. The first edge therefore writes the top six channels.
- R8: A start input held high over several clocks starts only one run; it does not restart the fill.
- R9: After the CHANNELS/6-th write, the buffer holds its contents against any data or inversion input until a new start rise.
- R10: The cascade output goes high in the cycle after the final write edge and stays high for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| pixIn | input | 36 | Six 6-bit values per clock, value k at bits 6k+5..6k |
| invLo | input | 1 | Complement values 0..2 |
| invHi | input | 1 | Complement values 3..5 |
| dirRight | input | 1 | 1: fill from channel 1 upward, A in / B out; 0: fill from top down, B in / A out |
| startA_in | input | 1 | Pin A input side |
| startA_out | output | 1 | Pin A output side (cascade when dirRight = 0) |
| startA_oe | output | 1 | Pin A output enable |
| startB_in | input | 1 | Pin B input side |
| startB_out | output | 1 | Pin B output side (cascade when dirRight = 1) |
| startB_oe | output | 1 | Pin B output enable |
| rowBuf | output | CHANNELS*6 | Row buffer, channel c at bits 6(c-1)+5..6(c-1) |

## Verification
The bench builds the block with CHANNELS = 24, so a row is four groups. Both ends of the buffer, the reversal of the fill order and the cascade timing are then reached within a few clocks per run. Every combination of direction and the two inversion controls is swept, with start pulses both one clock wide and held for the whole row. The full buffer image is predicted arithmetically from the channel mapping rules.

// File: rtl/rowcap_pkg.sv
package rowcap_pkg;

  // values delivered per clock and their width
  localparam int LANES = 6;
  localparam int VAL_W = 6;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic wrEn;    // write one group this edge
    logic lastWr;  // this write completes the row
  } strobe_t;

endpackage

// File: rtl/rowcap_ctrl.sv
module rowcap_ctrl #(
  parameter int STEPS = 67,
  parameter int IDXW  = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dirRight,
  input  logic                startIn,
  output rowcap_pkg::strobe_t strobes,
  output logic [IDXW-1:0]     wrIdx,
  output logic                cascadeQ
);
  import rowcap_pkg::*;

  localparam logic [IDXW-1:0] IDX_TOP   = IDXW'(STEPS - 1);
  localparam logic [IDXW-1:0] IDX_UP1   = IDXW'(1);
  localparam logic [IDXW-1:0] IDX_DN1   = IDXW'(STEPS - 2);
  localparam bit              MULTI     = (STEPS > 1);

  logic            startPrev;
  logic            active;
  logic            dirQ;
  logic [IDXW-1:0] idx;
  logic            rise;

  assign rise = startIn & ~startPrev;

  // write strobe, group index and end-of-row flag for this edge
  always_comb begin
    strobes = '0;
    wrIdx   = '0;
    if (rise) begin
      strobes.wrEn   = 1'b1;
      strobes.lastWr = !MULTI;
      wrIdx          = dirRight ? '0 : IDX_TOP;
    end else if (active) begin
      strobes.wrEn   = 1'b1;
      strobes.lastWr = dirQ ? (idx == IDX_TOP) : (idx == '0);
      wrIdx          = idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      startPrev <= 1'b0;
      active    <= 1'b0;
      dirQ      <= 1'b1;
      idx       <= '0;
      cascadeQ  <= 1'b0;
    end else begin
      startPrev <= startIn;
      cascadeQ  <= strobes.wrEn & strobes.lastWr;
      if (rise) begin
        dirQ   <= dirRight;
        active <= MULTI;
        idx    <= dirRight ? IDX_UP1 : IDX_DN1;
      end else if (active) begin
        if (strobes.lastWr) begin
          active <= 1'b0;
        end else if (dirQ) begin
          idx <= idx + IDXW'(1);
        end else begin
          idx <= idx - IDXW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/rowcap_datapath.sv
module rowcap_datapath #(
  parameter int CHANNELS = 402,
  parameter int STEPS    = 67,
  parameter int IDXW     = 7
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic [rowcap_pkg::LANES*rowcap_pkg::VAL_W-1:0] pixIn,
  input  logic                                    invLo,
  input  logic                                    invHi,
  input  rowcap_pkg::strobe_t                     strobes,
  input  logic [IDXW-1:0]                         wrIdx,
  output logic [CHANNELS*rowcap_pkg::VAL_W-1:0]   rowBuf
);
  import rowcap_pkg::*;

  localparam int GRP_W = LANES * VAL_W;
  localparam int HALF  = LANES / 2;

  logic [GRP_W-1:0] grpData;

  // per-lane inversion: lower half by invLo, upper half by invHi
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l < HALF) begin : g_lo
      assign grpData[l*VAL_W +: VAL_W] = pixIn[l*VAL_W +: VAL_W] ^ {VAL_W{invLo}};
    end else begin : g_hi
      assign grpData[l*VAL_W +: VAL_W] = pixIn[l*VAL_W +: VAL_W] ^ {VAL_W{invHi}};
    end
  end

  // one register group of six channels per step
  for (genvar g = 0; g < STEPS; g++) begin : g_grp
    logic [GRP_W-1:0] grpQ;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        grpQ <= '0;
      end else if (strobes.wrEn && (wrIdx == IDXW'(g))) begin
        grpQ <= grpData;
      end
    end
    assign rowBuf[g*GRP_W +: GRP_W] = grpQ;
  end

endmodule

// File: rtl/rowcap_top.sv
module rowcap_top #(
  parameter int CHANNELS = 402,
  localparam int STEPS   = CHANNELS / rowcap_pkg::LANES,
  localparam int IDXW    = (STEPS > 1) ? $clog2(STEPS) : 1,
  localparam int IN_W    = rowcap_pkg::LANES * rowcap_pkg::VAL_W,
  localparam int BUF_W   = CHANNELS * rowcap_pkg::VAL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IN_W-1:0]  pixIn,
  input  logic             invLo,
  input  logic             invHi,
  input  logic             dirRight,
  input  logic             startA_in,
  output logic             startA_out,
  output logic             startA_oe,
  input  logic             startB_in,
  output logic             startB_out,
  output logic             startB_oe,
  output logic [BUF_W-1:0] rowBuf
);
  import rowcap_pkg::*;

  if ((CHANNELS % LANES) != 0 || CHANNELS < LANES) begin : g_bad_cfg
    $error("CHANNELS must be a positive multiple of the lane count");
  end

  strobe_t         strobes;
  logic [IDXW-1:0] wrIdx;
  logic            cascadeQ;
  logic            startIn;

  // pin roles follow the direction input
  assign startIn    = dirRight ? startA_in : startB_in;
  assign startA_oe  = ~dirRight;
  assign startB_oe  = dirRight;
  assign startA_out = ~dirRight & cascadeQ;
  assign startB_out = dirRight & cascadeQ;

  rowcap_ctrl #(.STEPS(STEPS), .IDXW(IDXW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .dirRight (dirRight),
    .startIn  (startIn),
    .strobes  (strobes),
    .wrIdx    (wrIdx),
    .cascadeQ (cascadeQ)
  );

  rowcap_datapath #(.CHANNELS(CHANNELS), .STEPS(STEPS), .IDXW(IDXW)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .pixIn   (pixIn),
    .invLo   (invLo),
    .invHi   (invHi),
    .strobes (strobes),
    .wrIdx   (wrIdx),
    .rowBuf  (rowBuf)
  );

endmodule

// File: rtl/rowcap_checker.sv
module rowcap_checker #(
  parameter int CHANNELS = 402,
  localparam int STEPS   = CHANNELS / rowcap_pkg::LANES,
  localparam int RLW     = $clog2(STEPS + 1) + 1,
  localparam int BUF_W   = CHANNELS * rowcap_pkg::VAL_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                dirRight,
  input logic                startA_in,
  input logic                startB_in,
  input logic                startA_out,
  input logic                startA_oe,
  input logic                startB_out,
  input logic                startB_oe,
  input logic [BUF_W-1:0]    rowBuf,
  input rowcap_pkg::strobe_t strobes
);

  logic           selPrev;
  logic           selNow;
  logic           riseC;
  logic [RLW-1:0] runLen;
  logic           cascAny;

  assign selNow  = dirRight ? startA_in : startB_in;
  assign riseC   = selNow & ~selPrev;
  assign cascAny = startA_out | startB_out;

  // writes counted since the last observed start rise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selPrev <= 1'b0;
      runLen  <= '0;
    end else begin
      selPrev <= selNow;
      if (strobes.wrEn) begin
        runLen <= riseC ? RLW'(1) : runLen + RLW'(1);
      end
    end
  end

  // R10: cascade pulse lasts a single clock
  p_cascade_one_clock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cascAny |=> !cascAny);

  // R9: no write strobe means the buffer does not move
  p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.wrEn |=> $stable(rowBuf));

  // R6: cascade appears only after a full row of writes
  p_cascade_after_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cascAny |-> runLen == RLW'(STEPS));

  // R5: a pulse leaves only through an enabled pin
  p_pin_a_role_r5: assert property (@(posedge clk) disable iff (!rst_n)
    startA_out |-> startA_oe);

  p_pin_b_role_r5: assert property (@(posedge clk) disable iff (!rst_n)
    startB_out |-> startB_oe);

endmodule

bind rowcap_top rowcap_checker #(.CHANNELS(CHANNELS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dirRight   (dirRight),
  .startA_in  (startA_in),
  .startB_in  (startB_in),
  .startA_out (startA_out),
  .startA_oe  (startA_oe),
  .startB_out (startB_out),
  .startB_oe  (startB_oe),
  .rowBuf     (rowBuf),
  .strobes    (strobes)
);

// File: tb/rowcap_top_tb.sv
module rowcap_top_tb;

  localparam int CH    = 24;
  localparam int STEPS = CH / 6;
  localparam int BW    = CH * 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [35:0]   pixIn = '0;
  logic          invLo = 1'b0;
  logic          invHi = 1'b0;
  logic          dirRight = 1'b1;
  logic          startA_in = 1'b0;
  logic          startB_in = 1'b0;
  logic          startA_out, startA_oe, startB_out, startB_oe;
  logic [BW-1:0] rowBuf;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  rowcap_top #(.CHANNELS(CH)) u_dut (
    .clk(clk), .rst_n(rst_n), .pixIn(pixIn), .invLo(invLo), .invHi(invHi),
    .dirRight(dirRight), .startA_in(startA_in), .startA_out(startA_out),
    .startA_oe(startA_oe), .startB_in(startB_in), .startB_out(startB_out),
    .startB_oe(startB_oe), .rowBuf(rowBuf)
  );

  task automatic chkBit(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic chkBuf(input logic [BW-1:0] act, input logic [BW-1:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] dval(input int seed, input int s, input int k);
    return 6'(seed * 13 + s * 6 + k * 11 + 5);
  endfunction

  // one full row; hold keeps the start input high for the whole run (R8)
  task automatic runRow(input bit dir, input bit iL, input bit iH, input int seed, input bit hold);
    logic [BW-1:0] exp;
    exp = '0;
    for (int s = 0; s < STEPS; s++) begin
      @(negedge clk);
      dirRight = dir;
      invLo    = iL;
      invHi    = iH;
      if (dir) begin
        startA_in = (s == 0) || hold;
        startB_in = 1'b1;  // output-role pin driven high: must be ignored (R5)
      end else begin
        startB_in = (s == 0) || hold;
        startA_in = 1'b1;
      end
      for (int k = 0; k < 6; k++) begin
        int g;
        logic [5:0] v;
        v = dval(seed, s, k);
        pixIn[k*6 +: 6] = v;
        g = dir ? s : (STEPS - 1 - s);
        exp[(g*6 + k)*6 +: 6] = v ^ ((k < 3) ? {6{iL}} : {6{iH}});
      end
    end
    @(negedge clk);
    chkBit(dir ? startB_out : startA_out, 1'b1, "R10 cascade high after final write");
    chkBit(dir ? startA_out : startB_out, 1'b0, "R5 input-role pin silent");
    chkBit(startA_oe, ~dir, "R5 pin A enable");
    chkBit(startB_oe, dir, "R5 pin B enable");
    chkBuf(rowBuf, exp, dir ? "R2 R3 R4 R6 R8 ascending fill" : "R2 R3 R4 R7 R8 descending fill");
    startA_in = 1'b0;
    startB_in = 1'b0;
    pixIn     = ~pixIn;
    invLo     = ~iL;
    invHi     = ~iH;
    @(negedge clk);
    chkBit(startA_out | startB_out, 1'b0, "R10 cascade one clock wide");
    pixIn = 36'h5A5A5A5A5;
    repeat (2) @(negedge clk);
    chkBuf(rowBuf, exp, "R9 buffer holds after row");
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chkBuf(rowBuf, '0, "R1 buffer clear in reset");
    chkBit(startA_out | startB_out, 1'b0, "R1 outputs low in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chkBuf(rowBuf, '0, "R1 buffer clear after reset");
    for (int d = 1; d >= 0; d--) begin
      for (int m = 0; m < 4; m++) begin
        runRow(d[0], m[0], m[1], d * 4 + m + 1, m[0] ^ m[1]);
      end
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R6 watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule